// File: doc/BRIEF.md
# Synchronous Almost-Full Flag Generator

This block produces an active-low almost-full indication for a dual-clock FIFO. It works only in the write-clock domain. It takes three inputs: the FIFO's binary write pointer, the write enable of the current cycle, and the read pointer as Gray code from the read domain. The read pointer passes through a multi-stage synchronizer and is decoded back to binary. The block then subtracts it from the write count to get the occupancy the write side sees, and compares that occupancy against the effective depth minus a programmed offset.

The flag is a register clocked by the write clock. A write that reaches the threshold pulls it low on that same write edge. A read can clear it only after the read pointer has crossed the synchronizer, so the write side always sees reads late. A depth-mode input is captured while reset is held. In standard mode the effective depth equals the storage depth. In first-word-fall-through mode the output register adds one word, so the effective depth is one larger. The storage array and the empty-side flags belong to other blocks.

Top module: `afull_flag_gen`

## Requirements
- R1: While `wr_rst_n` is low at a rising `wr_clk` edge, `afull_n` is 1 after that edge, whatever the pointer inputs are.
- R2: `afull_n` goes to 0 on the rising `wr_clk` edge at which a write (`wr_en` = 1) brings the write-side occupancy to `D - m` words or more, where `m` is `afull_offset` and `D` is the effective depth.
- R3: `afull_n` returns to 1 on the first rising `wr_clk` edge at which the write-side occupancy is `D - m - 1` words or fewer.
- R4: A change of `rd_ptr_gray` that is stable at a rising `wr_clk` edge first affects `afull_n` on the second edge after that one, which is the third edge counting it. With the default two stages, a change that coincides with an edge may take one edge longer.
- R5: `afull_n` changes only at rising `wr_clk` edges and holds its value between them.
- R6: `D` equals `DEPTH` when the captured mode is standard and `DEPTH + 1` when it is first-word-fall-through.
- R7: The mode is taken from `fwft_sel` only while `wr_rst_n` is low. Changing `fwft_sel` after reset has no effect on `afull_n`.
- R8: An offset `m` of `D` or more gives a threshold of one word, so any non-empty FIFO shows `afull_n` = 0.
- R9: The pointers are `PTR_W`-bit counters that wrap modulo 2^`PTR_W`, and the occupancy is computed modulo the same value. The flag stays correct across pointer wrap.
- R10: `rd_ptr_gray` is the read count `b` encoded as `b ^ (b >> 1)`, truncated to `PTR_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Synchronous active-low master reset |
| fwft_sel | input | 1 | Depth mode, captured during reset: 1 selects first-word-fall-through |
| wr_en | input | 1 | A word is written on this edge |
| wr_ptr | input | PTR_W | Binary write count before this edge's write |
| rd_ptr_gray | input | PTR_W | Gray-coded read count from the read domain |
| afull_offset | input | OFF_W | Almost-full offset m; change only while in reset or idle |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
The bound checker watches every cycle for the following. The flag is held high in reset. It can only fall after a write. It can only rise after the synchronized read count has moved. It stays low while that count is steady. The captured mode never moves outside reset. What it cannot show is whether the flag switches at the right occupancy. The bench's occupancy model covers this: the exact threshold in each mode, the clamped offset, the three-edge read latency, and correct behaviour over pointer wrap.

// File: rtl/afull_pkg.sv
// Shared definitions for the almost-full flag generator.
// Assumes: nothing beyond IEEE 1800-2017.
package afull_pkg;

    // Effective depth selection captured at reset.
    typedef enum logic {
        DEPTH_STD  = 1'b0,
        DEPTH_FWFT = 1'b1
    } depth_mode_e;

    // Pointer width able to hold DEPTH+1 words with one wrap bit of margin.
    function automatic int unsigned ptr_width(input int unsigned depth);
        return $clog2(depth + 1) + 1;
    endfunction

    // Offset width able to express any offset up to DEPTH+1.
    function automatic int unsigned off_width(input int unsigned depth);
        return $clog2(depth + 2);
    endfunction

endpackage

// File: rtl/afull_gray_sync.sv
// Carries a Gray-coded pointer into the local clock domain through a
// chain of STAGES flops, then decodes the last stage back to binary.
// Assumes: the source changes at most one bit between samples, as
// Gray counters do; STAGES >= 2.
module afull_gray_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    // Shift the Gray value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    // Gray to binary: each bit is the XOR of itself and all higher bits.
    for (genvar b = 0; b < W; b++) begin : g_dec
        assign bin_out[b] = ^stage_q[LAST][W-1:b];
    end

endmodule

// File: rtl/afull_level.sv
// Write-side occupancy: the write count including this cycle's write,
// minus the synchronized read count, modulo 2^PTR_W.
// Assumes: true occupancy never exceeds 2^(PTR_W-1).
module afull_level #(
    parameter int unsigned PTR_W = 6
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] rd_bin,
    output logic [PTR_W-1:0] occ
);
    logic [PTR_W-1:0] wr_inc;

    // Widen the write strobe to pointer width.
    always_comb begin
        wr_inc = {{(PTR_W-1){1'b0}}, wr_en};
    end

    // Look ahead by the current write so the flag falls on its edge.
    always_comb begin
        occ = wr_ptr + wr_inc - rd_bin;
    end

endmodule

// File: rtl/afull_limit.sv
// Threshold at which the flag asserts: effective depth minus offset,
// clamped to one word when the offset reaches the depth.
// Assumes: the offset is steady except during reset or idle.
module afull_limit #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned OFF_W = 5,
    parameter int unsigned PTR_W = 6
) (
    input  afull_pkg::depth_mode_e mode,
    input  logic [OFF_W-1:0]       offset,
    output logic [PTR_W-1:0]       thresh
);
    import afull_pkg::*;

    localparam int unsigned CMP_W = ((PTR_W > OFF_W) ? PTR_W : OFF_W) + 1;

    logic [CMP_W-1:0] full_d;
    logic [CMP_W-1:0] off_x;
    logic [CMP_W-1:0] diff;

    // Effective depth grows by the output register in fall-through mode.
    always_comb begin
        full_d = CMP_W'(DEPTH) + ((mode == DEPTH_FWFT) ? CMP_W'(1) : CMP_W'(0));
        off_x  = CMP_W'(offset);
    end

    // Subtract the offset, never going below one word.
    always_comb begin
        if (off_x >= full_d) begin
            diff = CMP_W'(1);
        end else begin
            diff = full_d - off_x;
        end
        thresh = diff[PTR_W-1:0];
    end

endmodule

// File: rtl/afull_flag_gen.sv
// Almost-full flag generator, registered entirely in the write domain.
// Captures the depth mode during reset, synchronizes the Gray read
// pointer, and asserts afull_n (low) while occupancy >= depth - offset.
// Assumes: wr_ptr and rd_ptr_gray are zero while reset is released.
module afull_flag_gen
    import afull_pkg::*;
#(
    parameter  int unsigned DEPTH       = 16,
    parameter  int unsigned SYNC_STAGES = 2,
    localparam int unsigned PTR_W       = ptr_width(DEPTH),
    localparam int unsigned OFF_W       = off_width(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             fwft_sel,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr_gray,
    input  logic [OFF_W-1:0] afull_offset,
    output logic             afull_n
);
    depth_mode_e      mode_q;
    logic [PTR_W-1:0] rd_bin_w;
    logic [PTR_W-1:0] occ_w;
    logic [PTR_W-1:0] thresh_w;

    // Capture the depth mode only while master reset is held.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            mode_q <= fwft_sel ? DEPTH_FWFT : DEPTH_STD;
        end
    end

    afull_gray_sync #(
        .W      (PTR_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (rd_ptr_gray),
        .bin_out (rd_bin_w)
    );

    afull_level #(
        .PTR_W (PTR_W)
    ) u_level (
        .wr_ptr (wr_ptr),
        .wr_en  (wr_en),
        .rd_bin (rd_bin_w),
        .occ    (occ_w)
    );

    afull_limit #(
        .DEPTH (DEPTH),
        .OFF_W (OFF_W),
        .PTR_W (PTR_W)
    ) u_limit (
        .mode   (mode_q),
        .offset (afull_offset),
        .thresh (thresh_w)
    );

    // Register the flag on write edges only; high means not almost full.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            afull_n <= 1'b1;
        end else begin
            afull_n <= !(occ_w >= thresh_w);
        end
    end

endmodule

// File: rtl/afull_chk.sv
// Temporal checks for afull_flag_gen, attached through bind.
// Assumes: offset only moves during reset or idle.
module afull_chk #(
    parameter int unsigned PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             afull_n,
    input logic [PTR_W-1:0] rd_bin,
    input logic             mode_bit
);

    // R1
    reset_high_chk: assert property (@(posedge clk)
        !rst_n |=> afull_n);

    // R2
    fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(afull_n) |-> $past(wr_en));

    // R4
    rise_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(afull_n) |-> ($past(rd_bin) != $past(rd_bin, 2)));

    // R3
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(afull_n) && ($past(rd_bin) == $past(rd_bin, 2))) |-> !afull_n);

    // R7
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_bit));

endmodule

bind afull_flag_gen afull_chk #(
    .PTR_W (PTR_W)
) u_chk (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .wr_en    (wr_en),
    .afull_n  (afull_n),
    .rd_bin   (rd_bin_w),
    .mode_bit (mode_q)
);

// File: tb/sim_afull_flag_gen.sv
`timescale 1ns/1ps
module sim_afull_flag_gen;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned PTR_W = $clog2(DEPTH + 1) + 1;
    localparam int unsigned OFF_W = $clog2(DEPTH + 2);
    localparam int unsigned ROWS  = 8;

    // Row: [15:10] writes, [9:4] reads, [3:1] unused, [0] expected afull_n.
    // Standard mode, offset 3: asserts at 13 words.
    localparam logic [15:0] TBL [ROWS] = '{
        {6'd12, 6'd0,  3'd0, 1'b1},
        {6'd1,  6'd0,  3'd0, 1'b0},
        {6'd0,  6'd1,  3'd0, 1'b1},
        {6'd1,  6'd0,  3'd0, 1'b0},
        {6'd3,  6'd0,  3'd0, 1'b0},
        {6'd0,  6'd3,  3'd0, 1'b0},
        {6'd0,  6'd1,  3'd0, 1'b1},
        {6'd0,  6'd12, 3'd0, 1'b1}
    };

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             fwft  = 1'b0;
    logic             we    = 1'b0;
    logic [PTR_W-1:0] wp_bus = '0;
    logic [PTR_W-1:0] rg_bus = '0;
    logic [OFF_W-1:0] off    = '0;
    logic             afull_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int wp_m = 0, rd_m = 0, s1 = 0, s2 = 0, depth_m = DEPTH, off_m = 0;
    logic exp_m = 1'b1;

    always #2.5 clk = ~clk;

    afull_flag_gen #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
        .wr_clk       (clk),
        .wr_rst_n     (rst_n),
        .fwft_sel     (fwft),
        .wr_en        (we),
        .wr_ptr       (wp_bus),
        .rd_ptr_gray  (rg_bus),
        .afull_offset (off),
        .afull_n      (afull_n)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: afull_n=%0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic int thr_of();
        return (off_m >= depth_m) ? 1 : depth_m - off_m;
    endfunction

    function automatic logic [PTR_W-1:0] gray_of(input int v);
        logic [PTR_W-1:0] b;
        b = v[PTR_W-1:0];
        return b ^ (b >> 1);
    endfunction

    // One write-clock cycle with an occupancy model; two-stage read latency.
    task automatic step(input bit w, input bit r);
        @(negedge clk);
        chk(afull_n, exp_m, "R5 flag steady between write edges");
        we     = w;
        wp_bus = wp_m[PTR_W-1:0];
        if (r) begin
            rd_m++;
            rg_bus = gray_of(rd_m);
        end
        @(posedge clk);
        exp_m = !((wp_m + int'(w) - s2) >= thr_of());
        wp_m  = wp_m + int'(w);
        s2    = s1;
        s1    = rd_m;
        #1 chk(afull_n, exp_m, "R2 R3 R4 per-edge occupancy model");
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic do_reset(input bit mode, input int offv, input int junk);
        @(negedge clk);
        rst_n  = 1'b0;
        we     = 1'b0;
        fwft   = mode;
        off    = offv[OFF_W-1:0];
        wp_bus = junk[PTR_W-1:0];
        rg_bus = '0;
        repeat (3) @(posedge clk);
        #1 chk(afull_n, 1'b1, "R1 flag high during reset");
        @(negedge clk);
        wp_bus = '0;
        @(negedge clk);
        rst_n   = 1'b1;
        wp_m    = 0;
        rd_m    = 0;
        s1      = 0;
        s2      = 0;
        depth_m = DEPTH + int'(mode);
        off_m   = offv;
        exp_m   = 1'b1;
    endtask

    initial begin
        // R1: reset with a large write pointer still leaves the flag high.
        do_reset(1'b0, 3, 40);
        chk(afull_n, 1'b1, "R1 flag high after reset");

        // Table walk: R2 and R3 thresholds in standard mode.
        for (int r = 0; r < int'(ROWS); r++) begin
            writes(int'(TBL[r][15:10]));
            reads(int'(TBL[r][9:4]));
            idle(4);
            chk(afull_n, TBL[r][0], "R2 R3 table row");
        end

        // R2: the write that reaches D-m pulls the flag low on its own edge.
        do_reset(1'b0, 3, 0);
        writes(12);
        chk(afull_n, 1'b1, "R2 one word below threshold");
        writes(1);
        chk(afull_n, 1'b0, "R2 asserted on threshold write edge");

        // R4: a read reaches the flag on the third write edge.
        idle(3);
        step(1'b0, 1'b1);
        chk(afull_n, 1'b0, "R4 read not yet visible at edge 1");
        step(1'b0, 1'b0);
        chk(afull_n, 1'b0, "R4 read not yet visible at edge 2");
        step(1'b0, 1'b0);
        chk(afull_n, 1'b1, "R4 read visible at edge 3");

        // R6 and R7: fall-through mode, offset 0, depth 17.
        do_reset(1'b1, 0, 0);
        writes(16);
        chk(afull_n, 1'b1, "R6 16 words below fall-through depth");
        fwft = 1'b0;
        idle(3);
        chk(afull_n, 1'b1, "R7 mode pin ignored after reset");
        writes(1);
        chk(afull_n, 1'b0, "R6 asserted at 17 words");

        // R8: oversized offset clamps the threshold to one word.
        do_reset(1'b0, 20, 0);
        chk(afull_n, 1'b1, "R8 empty FIFO not almost full");
        writes(1);
        chk(afull_n, 1'b0, "R8 one word asserts flag");
        reads(1);
        idle(3);
        chk(afull_n, 1'b1, "R8 empty again clears flag");

        // R9 and R10: repeated fill and drain across pointer wrap.
        do_reset(1'b0, 3, 0);
        for (int k = 0; k < 5; k++) begin
            writes(14);
            chk(afull_n, 1'b0, "R9 asserted after wrap round fill");
            reads(14);
            idle(3);
            chk(afull_n, 1'b1, "R9 R10 cleared after Gray read drain");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule